// File: doc/BRIEF.md
# Configurable UART Transmit Engine

This block turns one character into a serial frame on a single output line. It sends the least significant bit first. The frame opens with a low start bit. The data bits follow, then an optional parity bit, then one or two high stop bits. Three control inputs choose the frame shape at the moment a character is accepted: a two-bit parity code, a character-length select and a stop-bit select. A one-cycle baud tick from an external rate generator paces the frame, and every bit lasts sixteen ticks.

The engine runs only while both the power input and the transmit-enable input are high. The transmit enable passes through a two-flop synchronizer before it is used. When the synchronized enable is low, or when power is low, the engine drops back to idle, and any frame in progress is abandoned. A data write is taken only once the synchronized enable has already been high for one full clock, and only while the engine is idle. When the last stop bit ends, a one-cycle completion pulse marks the end of the frame and the busy flag clears at the same time.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, and whenever the engine is not busy, the serial line is high (1), and the busy and done outputs are low.
- R2: A frame starts with one low start bit and sends the data bits least significant first. Each bit of the frame stays on the line for exactly 16 baud ticks, so a frame of N bits lasts 16*N ticks.
- R3: When `char8` is 1, the frame carries 8 data bits. When `char8` is 0, it carries 7 data bits (wdata[6:0]) and wdata[7] is not sent.
- R4: The `par_mode` code sets the parity bit that follows the data. Code 2'b00 adds no parity bit. Code 2'b01 adds a bit that is always 0. Code 2'b10 adds odd parity, so the sent data bits plus the parity bit hold an odd number of ones. Code 2'b11 adds even parity, so that count is even.
- R5: When `stop2` is 0, the frame ends with one high stop bit. When `stop2` is 1, it ends with two high stop bits.
- R6: `done` goes high for exactly one clock, right after the 16th tick of the last stop bit. `busy` falls in that same cycle.
- R7: `tx_en` passes through two synchronizing flops before use. A write (`wstb` high at a rising edge) starts a frame only if `pwr_en` is 1 and the synchronized enable was already 1 before the previous edge. A strobe at the 1st, 2nd or 3rd edge after `tx_en` rises is therefore ignored. A strobe is also ignored while `pwr_en` or `tx_en` is low.
- R8: A write made while a frame is busy is ignored. The frame in flight keeps its own data, and no second frame follows it.
- R9: When `tx_en` goes low, the synchronizer still holds the engine busy at the first edge. The engine is idle, with the line high, after the third edge. When `pwr_en` goes low, the engine is idle after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit |
| pwr_en | input | 1 | Power enable for the engine |
| tx_en | input | 1 | Transmit enable (asynchronous, synchronized inside) |
| par_mode | input | 2 | Parity code: 00 none, 01 zero, 10 odd, 11 even |
| char8 | input | 1 | 1 sends 8 data bits, 0 sends 7 |
| stop2 | input | 1 | 1 sends two stop bits, 0 sends one |
| wdata | input | 8 | Character to send |
| wstb | input | 1 | Write strobe for wdata |
| txd | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
A write is accepted at a rising edge. Busy and the start bit are then visible at the next falling edge, and the bench checks both there. The bench records the line at every falling edge that comes before a baud tick. From those records it takes each bit at its 8th tick, and it checks the total tick count against 16 times the expected bit count. The done pulse is checked at the falling edge right after the last recorded tick, and its absence is checked one clock later. For an abort, the line and busy are checked one falling edge after the edge where they must change. An earlier sample is also taken where the old state must still hold.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        par_mode_e par;
        logic      char8;
        logic      stop2;
    } frame_cfg_t;

    // Parity bit from the mode and the xor of the data bits that are sent
    function automatic logic pick_parity(par_mode_e mode, logic ones_odd);
        case (mode)
            PAR_ODD:  pick_parity = ~ones_odd;
            PAR_EVEN: pick_parity = ones_odd;
            default:  pick_parity = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_enable_gate.sv
module uart_tx_enable_gate #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_en,
    input  logic tx_en,
    output logic active,
    output logic write_ok
);
    logic [STAGES-1:0] sync_q;
    logic              armed_q;

    // Shift tx_en through the synchronizer flops
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tx_en};
        end
    end

    assign active = pwr_en & sync_q[STAGES-1];

    // armed_q is set one clock after the engine becomes active
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assign write_ok = active & armed_q;

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              baud_tick,
    input  logic              load,
    input  frame_cfg_t        load_cfg,
    input  logic [DATA_W-1:0] load_data,
    output logic              tx,
    output logic              busy,
    output logic              done
);
    localparam int TICK_W = $clog2(OVERSAMPLE);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0]  IDX_LONG  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0]  IDX_SHORT = IDX_W'(DATA_W - 2);

    tx_state_e         state;
    logic [TICK_W-1:0] tick_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic              stop_sel_q;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] masked;
    logic              bit_end;
    logic [IDX_W-1:0]  last_idx;

    // In short-character mode the top data bit is dropped
    assign masked   = load_cfg.char8 ? load_data : {1'b0, load_data[DATA_W-2:0]};
    assign bit_end  = baud_tick && (tick_q == LAST_TICK);
    assign last_idx = cfg_q.char8 ? IDX_LONG : IDX_SHORT;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state      <= ST_IDLE;
            tick_q     <= '0;
            idx_q      <= '0;
            shreg      <= '0;
            par_q      <= 1'b0;
            stop_sel_q <= 1'b0;
            cfg_q      <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (load) begin
                    state  <= ST_START;
                    tick_q <= '0;
                    cfg_q  <= load_cfg;
                    shreg  <= masked;
                    par_q  <= pick_parity(load_cfg.par, ^masked);
                end
            end else if (baud_tick) begin
                tick_q <= bit_end ? '0 : tick_q + 1'b1;
                if (bit_end) begin
                    case (state)
                        ST_START: begin
                            state <= ST_DATA;
                            idx_q <= '0;
                        end
                        ST_DATA: begin
                            shreg <= shreg >> 1;
                            if (idx_q == last_idx) begin
                                stop_sel_q <= 1'b0;
                                state <= (cfg_q.par == PAR_NONE) ? ST_STOP : ST_PAR;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                        ST_PAR: begin
                            stop_sel_q <= 1'b0;
                            state      <= ST_STOP;
                        end
                        ST_STOP: begin
                            if (cfg_q.stop2 && !stop_sel_q) begin
                                stop_sel_q <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (state)
            ST_START: tx = 1'b0;
            ST_DATA:  tx = shreg[0];
            ST_PAR:   tx = par_q;
            default:  tx = 1'b1;
        endcase
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              pwr_en,
    input  logic              tx_en,
    input  logic [1:0]        par_mode,
    input  logic              char8,
    input  logic              stop2,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wstb,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    logic       active;
    logic       write_ok;
    frame_cfg_t cfg;

    assign cfg.par   = par_mode_e'(par_mode);
    assign cfg.char8 = char8;
    assign cfg.stop2 = stop2;

    uart_tx_enable_gate #(
        .STAGES(SYNC_STAGES)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .pwr_en  (pwr_en),
        .tx_en   (tx_en),
        .active  (active),
        .write_ok(write_ok)
    );

    uart_tx_serializer #(
        .DATA_W    (DATA_W),
        .OVERSAMPLE(OVERSAMPLE)
    ) u_ser (
        .clk      (clk),
        .rst      (rst),
        .clear    (!active),
        .baud_tick(baud_tick),
        .load     (wstb && write_ok),
        .load_cfg (cfg),
        .load_data(wdata),
        .tx       (txd),
        .busy     (busy),
        .done     (done)
    );

endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk (
    input logic clk,
    input logic rst,
    input logic pwr_en,
    input logic wstb,
    input logic txd,
    input logic busy,
    input logic done
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd); // R1

    AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R6

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wstb) && $past(pwr_en))); // R7

    AST_POWER_OFF_IDLES: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !busy); // R9

endmodule

bind uart_tx_engine uart_tx_engine_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .pwr_en(pwr_en),
    .wstb  (wstb),
    .txd   (txd),
    .busy  (busy),
    .done  (done)
);

// File: tb/sim_uart_tx_engine.sv
module sim_uart_tx_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick;
    logic       pwr_en = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       char8 = 1'b1;
    logic       stop2 = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       wstb = 1'b0;
    logic       txd;
    logic       busy;
    logic       done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    // Baud tick every 4 clocks, from a counter updated at the rising edge
    logic [1:0] tick_div = 2'd0;
    always @(posedge clk) tick_div <= tick_div + 2'd1;
    assign baud_tick = (tick_div == 2'd3);

    uart_tx_engine u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .pwr_en(pwr_en),
        .tx_en(tx_en), .par_mode(par_mode), .char8(char8), .stop2(stop2),
        .wdata(wdata), .wstb(wstb), .txd(txd), .busy(busy), .done(done)
    );

    // Fields: [11:10] parity code, [9] char8, [8] stop2, [7:0] data
    localparam logic [11:0] VEC [16] = '{
        {2'b00, 1'b1, 1'b0, 8'hA5}, {2'b00, 1'b1, 1'b1, 8'h3C},
        {2'b00, 1'b0, 1'b0, 8'hC1}, {2'b00, 1'b0, 1'b1, 8'h7E},
        {2'b01, 1'b1, 1'b0, 8'hFF}, {2'b01, 1'b1, 1'b1, 8'h01},
        {2'b01, 1'b0, 1'b0, 8'h55}, {2'b01, 1'b0, 1'b1, 8'hAA},
        {2'b10, 1'b1, 1'b0, 8'h00}, {2'b10, 1'b1, 1'b1, 8'h81},
        {2'b10, 1'b0, 1'b0, 8'hE3}, {2'b10, 1'b0, 1'b1, 8'h96},
        {2'b11, 1'b1, 1'b0, 8'h07}, {2'b11, 1'b1, 1'b1, 8'hFE},
        {2'b11, 1'b0, 1'b0, 8'h80}, {2'b11, 1'b0, 1'b1, 8'h4B}
    };

    logic rec [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [11:0] v, input bit inject);
        logic [1:0] pm;
        logic       l8, s2, pbit, exp_p;
        logic [7:0] d, got;
        int nd, np, ns, nb, n, guard, inj;
        pm = v[11:10]; l8 = v[9]; s2 = v[8]; d = v[7:0];
        nd = l8 ? 8 : 7;
        np = (pm != 2'b00) ? 1 : 0;
        ns = s2 ? 2 : 1;
        nb = 1 + nd + np + ns;
        if (!l8) d[7] = 1'b0;
        case (pm)
            2'b10:   exp_p = ($countones(d) % 2 == 0);
            2'b11:   exp_p = ($countones(d) % 2 == 1);
            default: exp_p = 1'b0;
        endcase
        @(negedge clk);
        par_mode = pm; char8 = l8; stop2 = s2; wdata = v[7:0]; wstb = 1'b1;
        @(negedge clk);
        wstb = 1'b0;
        chk(busy == 1'b1, "R7", "write accepted when enabled", int'(busy), 1);
        chk(txd == 1'b0, "R2", "start bit low after accept", int'(txd), 0);
        n = 0; guard = 0; inj = 0;
        while (!done && guard < 5000) begin
            if (baud_tick && n < 256) begin
                rec[n] = txd;
                n++;
            end
            if (inject && inj == 0 && n == 40) begin
                wdata = ~v[7:0]; wstb = 1'b1; inj = 1;
            end else if (inj == 1) begin
                wstb = 1'b0; inj = 2;
            end
            @(negedge clk);
            guard++;
        end
        chk(n == 16 * nb, "R2", "ticks per frame (16 per bit)", n, 16 * nb);
        chk(done == 1'b1 && busy == 1'b0, "R6", "done with busy low",
            int'({done, busy}), 2);
        chk(rec[8] == 1'b0, "R2", "start bit", int'(rec[8]), 0);
        got = 8'h00;
        for (int k = 0; k < nd; k++) got[k] = rec[16 * (1 + k) + 8];
        chk(got == d, (inject ? "R8" : "R3"), "data bits lsb first", int'(got), int'(d));
        if (np == 1) begin
            pbit = rec[16 * (1 + nd) + 8];
            chk(pbit == exp_p, "R4", "parity bit", int'(pbit), int'(exp_p));
        end
        for (int j = 0; j < ns; j++) begin
            chk(rec[16 * (1 + nd + np + j) + 8] == 1'b1, "R5", "stop bit high",
                int'(rec[16 * (1 + nd + np + j) + 8]), 1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", "done lasts one clock", int'(done), 0);
        if (inject) begin
            chk(busy == 1'b0 && txd == 1'b1, "R8", "no frame queued from busy write",
                int'({busy, txd}), 1);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1 && busy == 1'b0 && done == 1'b0, "R1", "reset state",
            int'({txd, busy, done}), 4);

        // Power on but transmit disabled: writes ignored
        pwr_en = 1'b1;
        repeat (3) @(negedge clk);
        wstb = 1'b1; wdata = 8'h12;
        @(negedge clk);
        wstb = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b1, "R7", "write while tx_en low ignored",
            int'({busy, txd}), 1);

        // Strobe held over the first three edges after tx_en rises
        tx_en = 1'b1; wstb = 1'b1; wdata = 8'h34;
        repeat (3) @(negedge clk);
        wstb = 1'b0;
        chk(busy == 1'b0 && txd == 1'b1, "R7", "early write ignored",
            int'({busy, txd}), 1);

        // Every configuration combination
        for (int i = 0; i < 16; i++) run_frame(VEC[i], 1'b0);

        // Write while busy
        run_frame({2'b11, 1'b1, 1'b1, 8'h5A}, 1'b1);

        // Abort through tx_en
        @(negedge clk);
        par_mode = 2'b00; char8 = 1'b1; stop2 = 1'b0; wdata = 8'h00; wstb = 1'b1;
        @(negedge clk);
        wstb = 1'b0;
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R9", "still busy one edge after tx_en falls", int'(busy), 1);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b1, "R9", "idle three edges after tx_en falls",
            int'({busy, txd}), 1);
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        repeat (4) @(negedge clk);
        run_frame({2'b10, 1'b0, 1'b0, 8'h2D}, 1'b0);

        // Abort through power
        @(negedge clk);
        wdata = 8'hF0; wstb = 1'b1;
        @(negedge clk);
        wstb = 1'b0;
        repeat (30) @(negedge clk);
        pwr_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b1, "R9", "idle one edge after power off",
            int'({busy, txd}), 1);
        wstb = 1'b1;
        @(negedge clk);
        wstb = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b1, "R7", "write ignored while power off",
            int'({busy, txd}), 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule